// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial bus in front of a 128-byte memory. It takes the bus clock and data lines as ordinary inputs, brings them into the system clock domain, and finds start and stop conditions and the clock edges. It drives the data line only through an open-drain enable: `sda_oe` high means "pull SDA low".

A transfer opens with a select byte. Its upper four bits are a fixed type code, the next three bits come from strap inputs, and the last bit gives the direction. After a write-direction select, the next byte loads the 7-bit address counter, and every byte after that is handed downstream as write data. Read-direction selects stream bytes out of the memory port, starting at the counter. A random read is a write-direction select plus an address byte, then a repeated start and a read-direction select. While the downstream page-write logic reports an internal write in progress, the engine does not acknowledge any select. A master can therefore poll for completion.

Write bytes leave on a valid/ready stream. `wr_valid` stays high, with address and data held, until `wr_ready` is seen high on a clock edge. The engine has a single holding slot. A data byte that finishes while the slot is still full is refused: it gets no acknowledge and is never presented. A one-cycle `wr_commit` tells the page-write logic to start its internal write. The memory read port has a fixed latency of one clock: `rd_data` must be valid on the cycle after `rd_en`.

Top module: `twi_mem_slave`

## Requirements
- R1: A fall of SDA while SCL is high (start) restarts select-byte reception from any state, including the middle of a byte, and releases SDA. A rise of SDA while SCL is high (stop) returns the engine to idle with SDA released.
- R2: A select byte, sent MSB first, matches when bits 7..4 equal 1010 and bits 3..1 equal `strap[2:0]`. Bit 0 = 1 means read and 0 means write. On a match, SDA is pulled low for the ninth clock. On a mismatch there is no acknowledge, and all bus activity is ignored until the next start or stop.
- R3: `sda_oe` changes only while SCL is low, that is, after an SCL falling edge has been seen.
- R4: After a write select, the next byte is acknowledged and its low 7 bits load the address counter. Bit 7 is ignored.
- R5: Each later data byte is acknowledged and presented on `wr_data`, with `wr_addr` equal to the counter. The counter then advances only its low two bits (wrapping within a 4-byte page), and the upper five bits stay fixed.
- R6: `wr_valid` with `wr_data` and `wr_addr` stays stable until accepted by `wr_ready`. A data byte that ends while `wr_valid` is still high is not acknowledged and not presented.
- R7: A stop after at least one presented data byte gives exactly one single-cycle `wr_commit` pulse.
- R8: A read select, when no address byte has been written since the last read, returns the byte at the counter. The counter holds the last accessed address plus one.
- R9: A write select plus address byte, then a repeated start and a read select, returns the byte at the loaded address.
- R10: In a read, the counter advances across all seven bits (127 wraps to 0) after each byte. If the master pulls SDA low in the ninth clock, the next byte follows. If SDA is high there, the engine drives nothing until a start or stop.
- R11: While `wbusy` is high, no select byte is acknowledged.
- R12: The engine releases SDA during the master's acknowledge slot in a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_oe | output | 1 | 1 = pull the data line low |
| strap | input | 3 | Select-address strap bits |
| wbusy | input | 1 | Internal write in progress downstream |
| wr_valid | output | 1 | Write byte available |
| wr_ready | input | 1 | Downstream accepts write byte |
| wr_addr | output | 7 | Address of write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse: start internal write |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 7 | Memory read address |
| rd_data | input | 8 | Read byte, valid one cycle after `rd_en` |

## Verification
A wrong address counter shows up as a wrong byte at the very next read, or as a wrong `wr_addr` on the next presented write byte. Page-wrap and 127-to-0 wrap faults appear only once a burst crosses a boundary, so bursts are aimed at those edges. A wrong protocol state shows within one byte time: a missing or extra acknowledge in the ninth clock, or data bits driven where the bus should float (read back as ones). Drive timing faults are caught on the cycle `sda_oe` moves while SCL is high.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ACK, S_WADDR, S_WDATA, S_TXB, S_MACK, S_MNXT, S_IGN
  } eng_st_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/twi_line_sampler.sv
module twi_line_sampler #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC-1:0] scl_q, sda_q;
  logic scl_s, scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q[0] <= scl_i;
      sda_q[0] <= sda_i;
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  for (genvar k = 1; k < SYNC; k++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_q[k] <= 1'b1;
        sda_q[k] <= 1'b1;
      end else begin
        scl_q[k] <= scl_q[k-1];
        sda_q[k] <= sda_q[k-1];
      end
    end
  end

  assign scl_s    = scl_q[SYNC-1];
  assign sda_s    = sda_q[SYNC-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
  parameter int AW        = 7,
  parameter int PAGE_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc_all,
  input  logic          inc_page,
  output logic [AW-1:0] q
);
  localparam logic [PAGE_BITS-1:0] PONE = PAGE_BITS'(1);
  logic [AW-1:0] page_next;

  assign page_next = {q[AW-1:PAGE_BITS], q[PAGE_BITS-1:0] + PONE};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load)     q <= load_val;
    else if (inc_page) q <= page_next;
    else if (inc_all)  q <= q + AW'(1);
  end
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave #(
  parameter int AW   = 7,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    strap,
  input  logic          wbusy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_commit,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  import twi_pkg::*;

  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL = CW'(DW);
  localparam logic [CW-1:0] ONE  = CW'(1);

  eng_st_t st, nxt;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] shreg, txreg, txsh;
  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic rd_en_d, wrote;
  logic quiet, byte_end, sel_match;
  logic ctr_load, ctr_inc_all, ctr_inc_page;
  logic [AW-1:0] ctr;
  logic in_mack;

  twi_line_sampler #(.SYNC(SYNC)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  twi_addr_ctr #(.AW(AW), .PAGE_BITS(2)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(shreg[AW-1:0]),
    .inc_all(ctr_inc_all), .inc_page(ctr_inc_page), .q(ctr)
  );

  assign quiet        = !start_ev && !stop_ev;
  assign byte_end     = quiet && scl_fall && (bitcnt == FULL);
  assign sel_match    = (shreg[DW-1:1] == {DEV_TYPE, strap}) && !wbusy;
  assign ctr_load     = byte_end && (st == S_WADDR);
  assign ctr_inc_page = byte_end && (st == S_WDATA) && !wr_valid;
  assign ctr_inc_all  = quiet && scl_rise && (st == S_MACK);
  assign rd_addr      = ctr;
  assign in_mack      = (st == S_MACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nxt       <= S_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      txreg     <= '0;
      txsh      <= '0;
      sda_oe    <= 1'b0;
      rd_en     <= 1'b0;
      rd_en_d   <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
      wrote     <= 1'b0;
    end else begin
      rd_en     <= 1'b0;
      rd_en_d   <= rd_en;
      wr_commit <= 1'b0;
      if (rd_en_d) txreg <= rd_data;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;

      if (start_ev) begin
        st     <= S_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (wrote) begin
          wr_commit <= 1'b1;
          wrote     <= 1'b0;
        end
      end else begin
        unique case (st)
          S_DEV, S_WADDR, S_WDATA: begin
            if (scl_rise && bitcnt != FULL) begin
              shreg  <= {shreg[DW-2:0], sda_s};
              bitcnt <= bitcnt + ONE;
            end else if (byte_end) begin
              st <= S_ACK;
              if (st == S_DEV) begin
                if (sel_match) begin
                  sda_oe <= 1'b1;
                  if (shreg[0]) begin
                    nxt   <= S_TXB;
                    rd_en <= 1'b1;
                  end else begin
                    nxt <= S_WADDR;
                  end
                end else begin
                  st <= S_IGN;
                end
              end else if (st == S_WADDR) begin
                sda_oe <= 1'b1;
                nxt    <= S_WDATA;
              end else if (!wr_valid) begin
                sda_oe   <= 1'b1;
                nxt      <= S_WDATA;
                wr_valid <= 1'b1;
                wr_data  <= shreg;
                wr_addr  <= ctr;
                wrote    <= 1'b1;
              end else begin
                st <= S_IGN;
              end
            end
          end
          S_ACK, S_MNXT: begin
            if (scl_fall) begin
              st <= nxt;
              if (st == S_MNXT || nxt == S_TXB) begin
                st     <= S_TXB;
                sda_oe <= ~txreg[DW-1];
                txsh   <= {txreg[DW-2:0], 1'b0};
                bitcnt <= ONE;
              end else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
              end
            end
          end
          S_TXB: begin
            if (scl_fall) begin
              if (bitcnt != FULL) begin
                sda_oe <= ~txsh[DW-1];
                txsh   <= {txsh[DW-2:0], 1'b0};
                bitcnt <= bitcnt + ONE;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                st    <= S_MNXT;
                rd_en <= 1'b1;
              end else begin
                st <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_mem_slave_chk.sv
module twi_mem_slave_chk #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic          wbusy,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          wr_commit,
  input logic          in_mack
);
  p_sda_only_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_deaf_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wbusy |-> !$rose(sda_oe));

  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  p_commit_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  p_mack_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_mack |-> !sda_oe);
endmodule

bind twi_mem_slave twi_mem_slave_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .wbusy(wbusy),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .wr_commit(wr_commit), .in_mack(in_mack)
);

// File: tb/sim_twi_mem_slave.sv
module sim_twi_mem_slave;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic wbusy, wr_valid, wr_ready = 1'b1, wr_commit, rd_en;
  logic [6:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] mem [0:127];
  logic [7:0] ref_mem [0:127];
  logic [6:0] lg_a [0:63];
  logic [7:0] lg_d [0:63];
  int lg_n = 0, commits = 0, busy_cnt = 0, r3_viol = 0;
  int total = 0, bad = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;
  assign wbusy = (busy_cnt != 0);

  twi_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap(STRAP), .wbusy(wbusy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_valid && wr_ready) begin
      mem[wr_addr] <= wr_data;
      if (lg_n < 64) begin
        lg_a[lg_n] = wr_addr;
        lg_d[lg_n] = wr_data;
      end
      lg_n = lg_n + 1;
    end
    if (wr_commit) begin
      commits = commits + 1;
      busy_cnt = 600;
    end else if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (rst_n && sda_oe != oe_prev && scl_m) r3_viol = r3_viol + 1;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic t_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic t_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic t_send(input logic [7:0] b, output logic nak);
    t_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); nak = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic t_recv(input bit ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = ack ? 1'b0 : 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    chk(sda_oe == 1'b0, "R12 slave releases in master ack slot", sda_oe, 0);
    wq(Q); scl_m = 1'b0; wq(Q); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] sel(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic poll_ready();
    logic nk;
    for (int i = 0; i < 40; i++) begin
      t_start(); t_send(sel(STRAP, 0), nk); t_stop();
      if (!nk) break;
    end
  endtask

  task automatic rand_read(input logic [6:0] a, output logic [7:0] d);
    logic nk;
    t_start(); t_send(sel(STRAP, 0), nk); t_send({1'b0, a}, nk);
    t_start(); t_send(sel(STRAP, 1), nk); t_recv(0, d); t_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic nk;
    logic [7:0] d, pd [0:5];
    logic [6:0] a;
    int n0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    wq(5); rst_n = 1'b1; wq(5);
    chk(!sda_oe && !wr_valid && !wr_commit, "R1 reset state", {sda_oe, wr_valid, wr_commit}, 0);

    // R2: wrong strap ignored, following byte floats
    t_start(); t_send(sel(3'b100, 0), nk);
    chk(nk == 1'b1, "R2 mismatch no ack", nk, 1);
    t_recv(0, d);
    chk(d == 8'hFF, "R2 ignored after mismatch", d, 8'hFF); t_stop();

    // R4/R5/R7: byte write, address MSB ignored
    n0 = commits;
    t_start(); t_send(sel(STRAP, 0), nk);
    chk(nk == 1'b0, "R2 matching select acked", nk, 0);
    t_send(8'h85, nk); chk(nk == 1'b0, "R4 address byte acked", nk, 0);
    t_send(8'h5A, nk); chk(nk == 1'b0, "R5 data byte acked", nk, 0);
    t_stop(); wq(4); ref_mem[5] = 8'h5A;
    chk(lg_n == 1 && lg_a[0] == 7'h05 && lg_d[0] == 8'h5A, "R4 write address msb ignored", lg_a[0], 7'h05);
    chk(commits == n0 + 1, "R7 single commit on stop", commits, n0 + 1);
    // R11: busy means no ack
    t_start(); t_send(sel(STRAP, 0), nk); t_stop();
    chk(nk == 1'b1, "R11 no ack while busy", nk, 1);
    poll_ready();
    chk(!wbusy, "R11 ack after busy ends", wbusy, 0);

    // R5: page write of 6 bytes from 0x1D wraps inside page
    n0 = lg_n;
    t_start(); t_send(sel(STRAP, 0), nk); t_send(8'h1D, nk);
    for (int i = 0; i < 6; i++) begin
      pd[i] = 8'($urandom);
      t_send(pd[i], nk);
      ref_mem[{5'b00111, 2'(2'd1 + 2'(i))}] = pd[i];
    end
    t_stop(); poll_ready();
    for (int i = 0; i < 6; i++)
      chk(lg_a[n0+i] == {5'b00111, 2'(2'd1 + 2'(i))} && lg_d[n0+i] == pd[i],
          "R5 page address low bits wrap", lg_a[n0+i], {5'b00111, 2'(2'd1 + 2'(i))});
    for (int i = 0; i < 4; i++) begin
      rand_read(7'h1C + 7'(i), d);
      chk(d == ref_mem[7'h1C + 7'(i)], "R5 page contents", d, ref_mem[7'h1C + 7'(i)]);
    end

    // R6: back-pressure refuses second byte
    wr_ready = 1'b0; n0 = lg_n;
    t_start(); t_send(sel(STRAP, 0), nk); t_send(8'h30, nk);
    t_send(8'hA1, nk); chk(nk == 1'b0, "R6 first byte acked with slot free", nk, 0);
    t_send(8'hB2, nk); chk(nk == 1'b1, "R6 second byte refused", nk, 1);
    chk(wr_valid && wr_data == 8'hA1, "R6 pending byte held", wr_data, 8'hA1);
    wr_ready = 1'b1; wq(4);
    chk(lg_n == n0 + 1 && lg_d[n0] == 8'hA1, "R6 refused byte not presented", lg_n - n0, 1);
    t_stop(); ref_mem[7'h30] = 8'hA1; poll_ready();

    // R9 random read, R8 current read, R1 start mid-byte
    rand_read(7'h40, d);
    chk(d == ref_mem[7'h40], "R9 random read", d, ref_mem[7'h40]);
    t_start(); t_send(sel(STRAP, 1), nk); t_recv(0, d); t_stop();
    chk(d == ref_mem[7'h41], "R8 current address read", d, ref_mem[7'h41]);
    t_start(); t_bits(sel(STRAP, 0), 4); t_start();
    t_send(sel(STRAP, 1), nk);
    chk(nk == 1'b0, "R1 start mid-byte restarts select", nk, 0);
    t_recv(0, d); t_stop();
    chk(d == ref_mem[7'h42], "R1 read after restart", d, ref_mem[7'h42]);

    // R10 sequential read wrapping 127 to 0, then nack ignores
    t_start(); t_send(sel(STRAP, 0), nk); t_send(8'h7E, nk);
    t_start(); t_send(sel(STRAP, 1), nk);
    for (int i = 0; i < 4; i++) begin
      t_recv(i != 3, d);
      chk(d == ref_mem[7'h7E + 7'(i)], "R10 sequential wrap", d, ref_mem[7'h7E + 7'(i)]);
    end
    t_recv(0, d);
    chk(d == 8'hFF, "R10 no drive after master nack", d, 8'hFF);
    t_stop();

    // random writes with polling and read-back
    for (int it = 0; it < 12; it++) begin
      a = 7'($urandom); d = 8'($urandom);
      t_start(); t_send(sel(STRAP, 0), nk); t_send({1'($urandom), a}, nk); t_send(d, nk); t_stop();
      ref_mem[a] = d; poll_ready();
      rand_read(a, d);
      chk(d == ref_mem[a], "R9 random write read-back", d, ref_mem[a]);
    end

    chk(r3_viol == 0, "R3 sda_oe changes only while scl low", r3_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule